// File: doc/BRIEF.md
# Calibration Sequencer with Completion Flag

This block collects requests for five calibration kinds and runs them one at a time against external calibration engines. Each engine gets a one-cycle start pulse and answers with a one-cycle done pulse. A host sets request bits by writing a 5-bit mask. Each bit stays set until its calibration has finished, so the host can poll the mask. When several bits are pending, the lowest-numbered bit always runs next. This gives a fixed run order: RF DC offset, then baseband DC offset, then Tx quadrature, then Rx quadrature, then gain step.

The sequencer keeps a per-kind busy vector and a combined completion flag. The flag is low out of reset and stays low until some calibration has completed. It is forced low whenever a run begins. It goes high only when a completion leaves nothing pending, so a batch written at once raises the flag a single time, at its end. A host can also read the state through an 8-bit status port. An 8-bit pointer register picks which group of signals appears on that port.

Top module: `cal_sequencer`

## Requirements
- R1: After reset the request mask, start pulses, busy vector, completion flag, pointer and status port are all zero.
- R2: Request bit k selects a kind: bit 0 RF DC, bit 1 baseband DC, bit 2 Tx quadrature, bit 3 Rx quadrature, bit 4 gain step. When the sequencer is idle with requests pending, it starts the lowest pending bit on the next clock edge and pulses that bit of `eng_start` for one cycle.
- R3: At most one kind is busy at a time. The busy bit rises with the start pulse and falls on the edge that samples that kind's `eng_done`.
- R4: A request bit clears on the edge that samples its engine's done pulse, unless the same bit is written again in that cycle.
- R5: The completion flag is low while any kind is busy. It rises on the completion edge only if no request remains pending after that edge. Otherwise it stays low until a later completion empties the mask.
- R6: From reset until the first completion, the completion flag stays low.
- R7: A done pulse from an engine that is not currently busy changes nothing.
- R8: Requests written while a calibration runs are added to the mask. They run after the current calibration, still lowest bit first.
- R9: With the pointer at 0x00, the status port shows the completion flag on bit 7 and the busy vector on bits 4:0. Bits 6:5 read zero.
- R10: With the pointer at 0x01, status bit 0 is RF DC busy and status bit 1 is baseband DC busy. All other bits read zero.
- R11: Any pointer value other than 0x00 and 0x01 drives the status port to all zeros.
- R12: A pointer write takes effect on the status port in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request mask write strobe |
| req_wdata | input | 5 | Request bits ORed into the mask |
| req_q | output | 5 | Pending request mask |
| eng_start | output | 5 | One-cycle start pulse per kind |
| eng_done | input | 5 | One-cycle done pulse per kind |
| busy | output | 5 | Running kind, one-hot or zero |
| cal_done | output | 1 | Combined completion flag |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | New pointer value |
| ctl_out | output | 8 | Pointer-selected status port |

## Verification
The bench writes multi-bit batches and checks that the completion flag stays low across the gaps between batch members. A design that raised the flag after each member would show a high pulse in those gaps. It watches the flag from reset through the first run; a design that inverted busy would show it high before any calibration had run. It sends done pulses from idle engines and adds requests in the middle of a run. These catch designs that clear the wrong bit, restart early or break the lowest-bit-first order. It also walks the pointer across the defined values and several undefined ones, where any leaked bit shows up on the port.

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int KINDS = 5,
  parameter int PTR_W = 8,
  parameter int OUT_W = 8,
  parameter logic [PTR_W-1:0] PTR_CAL = 8'h00,
  parameter logic [PTR_W-1:0] PTR_DC  = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [KINDS-1:0] req_wdata,
  output logic [KINDS-1:0] req_q,
  output logic [KINDS-1:0] eng_start,
  input  logic [KINDS-1:0] eng_done,
  output logic [KINDS-1:0] busy,
  output logic             cal_done,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  output logic [OUT_W-1:0] ctl_out
);
  localparam int IDX_W = (KINDS > 1) ? $clog2(KINDS) : 1;

  logic [KINDS-1:0] pend_q, start_q, pend_nxt, clr;
  logic [IDX_W-1:0] cur_q, pick;
  logic             run_q, done_q, finish;
  logic [PTR_W-1:0] ptr_q;

  assign busy      = run_q ? (KINDS'(1) << cur_q) : '0;
  assign finish    = |(busy & eng_done);
  assign clr       = finish ? busy : '0;
  assign pend_nxt  = (pend_q & ~clr) | (req_wr ? req_wdata : '0);
  assign req_q     = pend_q;
  assign eng_start = start_q;
  assign cal_done  = done_q;

  always_comb begin
    pick = '0;
    for (int i = KINDS - 1; i >= 0; i--)
      if (pend_q[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      start_q <= '0;
      cur_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      pend_q  <= pend_nxt;
      start_q <= '0;
      if (finish) begin
        run_q <= 1'b0;
        if (pend_nxt == '0) done_q <= 1'b1;
      end else if (!run_q && |pend_q) begin
        run_q   <= 1'b1;
        cur_q   <= pick;
        start_q <= KINDS'(1) << pick;
        done_q  <= 1'b0;
      end
      if (ptr_wr) ptr_q <= ptr_wdata;
    end
  end

  always_comb begin
    ctl_out = '0;
    if (ptr_q == PTR_CAL) begin
      ctl_out[OUT_W-1]   = done_q;
      ctl_out[KINDS-1:0] = busy;
    end else if (ptr_q == PTR_DC) begin
      ctl_out[0] = busy[0];
      ctl_out[1] = busy[1];
    end
  end

  // R3
  busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy));

  // R3
  start_matches_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_start) |-> (eng_start == busy));

  // R5
  done_low_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|busy) |-> !cal_done);

  // R4
  req_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(busy & eng_done)) && !req_wr) |=> ((req_q & $past(busy)) == '0));

  // R6
  done_rise_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> $past(|(busy & eng_done)));

  // R7
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|busy) && !req_wr) |=> (req_q == $past(req_q)));

  // R11
  undefined_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != PTR_CAL && ptr_q != PTR_DC) |-> (ctl_out == '0));
endmodule

// File: tb/tb_cal_sequencer.sv
module tb_cal_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_wr = 1'b0;
  logic [4:0] req_wdata = '0;
  logic [4:0] req_q, eng_start, busy;
  logic [4:0] eng_done = '0;
  logic       cal_done;
  logic       ptr_wr = 1'b0;
  logic [7:0] ptr_wdata = '0;
  logic [7:0] ctl_out;

  cal_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
    .req_q(req_q), .eng_start(eng_start), .eng_done(eng_done), .busy(busy),
    .cal_done(cal_done), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ctl_out(ctl_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  string ph = "R1";

  // reference state
  logic [4:0] m_pend = '0, m_start = '0, m_busy = '0;
  bit         m_done = 0, seen_done = 0;
  logic [7:0] m_ptr = '0;
  int         cnt[5] = '{0, 0, 0, 0, 0};
  int         extra = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ph, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_out();
    logic [7:0] o = '0;
    if (m_ptr == 8'h00) begin o[7] = m_done; o[4:0] = m_busy; end
    else if (m_ptr == 8'h01) begin o[0] = m_busy[0]; o[1] = m_busy[1]; end
    return o;
  endfunction

  task automatic tick(input bit wr, input logic [4:0] wd, input bit pw,
                      input logic [7:0] pd, input logic [4:0] spur);
    logic [4:0] dn = '0, clrm, nxt;
    bit fin;
    @(negedge clk);
    chk(req_q == m_pend, "R4", req_q, m_pend);
    chk(eng_start == m_start, "R2", eng_start, m_start);
    chk(busy == m_busy, "R3", busy, m_busy);
    chk(cal_done == m_done, seen_done ? "R5" : "R6", cal_done, m_done);
    chk(ctl_out == exp_out(), m_ptr == 8'h00 ? "R9" : (m_ptr == 8'h01 ? "R10" : "R11"),
        ctl_out, exp_out());
    for (int k = 0; k < 5; k++) begin
      if (cnt[k] > 0) begin cnt[k]--; if (cnt[k] == 0) dn[k] = 1'b1; end
      if (eng_start[k]) cnt[k] = 2 + k + extra;
    end
    dn = dn | (spur & ~m_busy);
    eng_done = dn; req_wr = wr; req_wdata = wd; ptr_wr = pw; ptr_wdata = pd;
    // next expected state
    fin = (m_busy & dn) != 0;
    clrm = fin ? m_busy : '0;
    nxt = (m_pend & ~clrm) | (wr ? wd : '0);
    m_start = '0;
    if (fin) begin
      m_busy = '0;
      if (nxt == 0) begin m_done = 1; seen_done = 1; end
    end else if (m_busy == 0 && m_pend != 0) begin
      for (int k = 4; k >= 0; k--) if (m_pend[k]) m_start = 5'(1 << k);
      m_busy = m_start;
      m_done = 0;
    end
    m_pend = nxt;
    if (pw) m_ptr = pd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, '0, 0, '0, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ph = "R1"; idle(3);
    chk(ctl_out == 8'h00 && cal_done == 1'b0, "R1", ctl_out, 0);

    ph = "R6 batch order R2";
    tick(1, 5'b10101, 0, '0, '0);
    idle(40);
    chk(cal_done == 1'b1 && req_q == 0, "R5", {req_q, cal_done}, 1);

    ph = "R8 late requests";
    tick(1, 5'b10000, 0, '0, '0);
    idle(3);
    tick(1, 5'b00011, 0, '0, '0);
    idle(4);
    tick(1, 5'b01000, 0, '0, '0);
    idle(40);

    ph = "R7 stray done";
    tick(1, 5'b00110, 0, '0, '0);
    for (int i = 0; i < 25; i++) tick(0, '0, 0, '0, 5'b11111);
    idle(10);
    for (int i = 0; i < 5; i++) tick(0, '0, 0, '0, 5'b11111);

    ph = "R10 R12 pointer";
    tick(1, 5'b00011, 1, 8'h01, '0);
    idle(20);
    ph = "R11 undefined ptr";
    tick(1, 5'b11111, 1, 8'h80, '0);
    idle(5);
    tick(0, '0, 1, 8'hFF, '0);
    idle(5);
    tick(0, '0, 1, 8'h02, '0);
    idle(5);
    tick(0, '0, 1, 8'h00, '0);
    idle(40);

    ph = "random mix";
    for (int i = 0; i < 600; i++) begin
      automatic bit wr = ($urandom_range(0, 9) == 0);
      automatic bit pw = ($urandom_range(0, 29) == 0);
      automatic logic [7:0] pv;
      case ($urandom_range(0, 3))
        0: pv = 8'h00; 1: pv = 8'h01; 2: pv = 8'h40; default: pv = 8'($urandom);
      endcase
      extra = $urandom_range(0, 3);
      tick(wr, 5'($urandom), pw, pv, ($urandom_range(0, 4) == 0) ? 5'($urandom) : 5'b0);
    end
    idle(60);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired [%s]", ph);
    finish_run();
  end
endmodule